// File: doc/BRIEF.md
# Shared-DAC Sample-and-Hold Refresh Sequencer

This block keeps a bank of analog sample-and-hold channels charged to their target voltages using one 12-bit DAC for all of them. A host stores a 12-bit target code per channel through a single-cycle write port. The sequencer then visits the channels one after another, forever. In each visit, called a slot, it drives the stored code onto the DAC and waits for the DAC output to settle. It then closes the analog switch of that channel and raises a sample strobe. Switch selection uses a one-hot bank enable together with a 3-bit address for an 8-way analog switch.

Slot timing comes from three cycle-count parameters. With the defaults and a 50 MHz clock, one pass over 32 channels takes about 900 µs. A loopback request names one channel. Once that channel's slot has finished, the block points the monitor multiplexer at the channel and raises a ready flag, so the host can read the held voltage through an 8-bit ADC. A one-cycle pulse marks the start of each full pass.

The slot controller has four named states:
- **LOAD** lasts 1 cycle and latches the code. It goes to SETTLE.
- **SETTLE** lasts SETTLE_CYC cycles. It goes to SAMPLE.
- **SAMPLE** lasts SAMPLE_CYC cycles, with the strobe and switch active. It goes to TAIL.
- **TAIL** lasts SLOT_CYC−1−SETTLE_CYC−SAMPLE_CYC cycles. It returns to LOAD and advances to the next channel, wrapping from the last channel to 0.

Synchronous reset puts the controller in LOAD on channel 0.

Top module: `shr_refresh_seq`

## Requirements
- R1: A synchronous reset sets every stored code to mid-scale 0x800, sets dac_code to 0x800, clears lb_ready, and restarts the sequence with the LOAD cycle of channel 0 in the first cycle after reset.
- R2: Channels are visited in ascending order 0, 1, …, NUM_CH−1, then 0 again. Every slot lasts exactly SLOT_CYC cycles, and the LOAD cycle comes first in the slot.
- R3: Within a slot, sample_strobe is low during LOAD and during the SETTLE_CYC cycles after it. It is then high for exactly SAMPLE_CYC consecutive cycles, and low for the rest of the slot.
- R4: mux_addr equals the channel number bits [2:0]. bank_en is all-zero while sample_strobe is low. While sample_strobe is high, bank_en has exactly one bit set, at the index given by channel bits [4:3].
- R5: dac_code takes the code of the slot's channel in the cycle after LOAD, and holds it unchanged through the rest of the slot.
- R6: A write of wr_code to channel wr_ch when wr_en is high, captured before that channel's LOAD cycle ends, is the code driven in that channel's next slot. This includes a write captured at the clock edge that starts the LOAD cycle.
- R7: A write to the channel whose slot is active, including one captured at the edge that ends its LOAD cycle, does not change dac_code in that slot. It takes effect one pass later.
- R8: A loopback request (lb_req high, channel lb_ch) clears lb_ready at once. After the first end of lb_ch's slot that comes after the request is captured, lb_ready rises in the next cycle with mon_sel equal to lb_ch. Both then hold until the next request.
- R9: pass_start is high only in the LOAD cycle of channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe |
| wr_ch | input | 5 | Channel written |
| wr_code | input | 12 | Code written |
| lb_req | input | 1 | Loopback request pulse |
| lb_ch | input | 5 | Channel to loop back |
| dac_code | output | 12 | Code driven to the shared DAC |
| bank_en | output | 4 | One-hot switch bank enable, sample window only |
| mux_addr | output | 3 | Address for the 8-way analog switch |
| sample_strobe | output | 1 | Sample window strobe |
| pass_start | output | 1 | Pulse at the start of each full pass |
| mon_sel | output | 5 | Channel routed to the monitor ADC |
| lb_ready | output | 1 | Loopback routed and ready |

## Verification
The bench runs a scoreboard that predicts, for every slot, the channel, the code and the exact cycle the strobe should rise. It therefore catches a wrong visit order, a shifted settle interval, or a wrong sample length. It places writes at the slot boundaries:
- one cycle before a channel's LOAD, which must apply in that same slot;
- in the LOAD cycle itself, which must wait a whole pass;
- in the middle of the channel's own slot.
A design that reads the register file one cycle late, or that lets a write through to the DAC during a sample, would show the new code one pass early or would show a changed dac_code during the strobe. The loopback tests include a request captured exactly at the named channel's slot end and a request on the last channel. A design that accepted a slot end already in progress would raise ready a full pass too early. A design that kept ready high across a new request would also be caught. A mid-run reset must bring every channel back to 0x800.

// File: rtl/shr_pkg.sv
package shr_pkg;

    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_SAMPLE = 2'd2,
        ST_TAIL   = 2'd3
    } slot_state_e;

endpackage

// File: rtl/shr_code_bank.sv
module shr_code_bank #(
    parameter int NUM_CH = 32,
    parameter int CODE_W = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [$clog2(NUM_CH)-1:0] wr_ch,
    input  logic [CODE_W-1:0]         wr_code,
    input  logic [$clog2(NUM_CH)-1:0] rd_ch,
    output logic [CODE_W-1:0]         rd_code
);
    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

    logic [CODE_W-1:0] codes [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                codes[g] <= MID_CODE;
            end else if (wr_en && (wr_ch == ($clog2(NUM_CH))'(g))) begin
                codes[g] <= wr_code;
            end
        end
    end

    assign rd_code = codes[rd_ch];

endmodule

// File: rtl/shr_slot_fsm.sv
module shr_slot_fsm
    import shr_pkg::*;
#(
    parameter int NUM_CH     = 32,
    parameter int SLOT_CYC   = 1406,
    parameter int SETTLE_CYC = 500,
    parameter int SAMPLE_CYC = 600
) (
    input  logic                      clk,
    input  logic                      rst,
    output logic [$clog2(NUM_CH)-1:0] cur_ch,
    output logic                      load_now,
    output logic                      sample_win,
    output logic                      slot_end,
    output logic                      pass_start
);
    localparam int CH_W     = $clog2(NUM_CH);
    localparam int TAIL_CYC = SLOT_CYC - 1 - SETTLE_CYC - SAMPLE_CYC;
    localparam int CNT_W    = $clog2(SLOT_CYC);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_CYC - 1);
    localparam logic [CNT_W-1:0] TAIL_LAST   = CNT_W'(TAIL_CYC - 1);
    localparam logic [CH_W-1:0]  LAST_CH     = CH_W'(NUM_CH - 1);

    slot_state_e          state;
    logic [CNT_W-1:0]     cnt;
    logic [CH_W-1:0]      ch;

    // state register process
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_LOAD;
            cnt   <= '0;
            ch    <= '0;
        end else begin
            unique case (state)
                ST_LOAD: begin
                    state <= ST_SETTLE;
                    cnt   <= '0;
                end
                ST_SETTLE: begin
                    if (cnt == SETTLE_LAST) begin
                        state <= ST_SAMPLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SAMPLE: begin
                    if (cnt == SAMPLE_LAST) begin
                        state <= ST_TAIL;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (cnt == TAIL_LAST) begin
                        state <= ST_LOAD;
                        cnt   <= '0;
                        ch    <= (ch == LAST_CH) ? '0 : ch + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // output process
    always_comb begin
        load_now   = 1'b0;
        sample_win = 1'b0;
        slot_end   = 1'b0;
        pass_start = 1'b0;
        unique case (state)
            ST_LOAD: begin
                load_now   = 1'b1;
                pass_start = (ch == '0);
            end
            ST_SETTLE: ;
            ST_SAMPLE: sample_win = 1'b1;
            ST_TAIL:   slot_end = (cnt == TAIL_LAST);
        endcase
    end

    assign cur_ch = ch;

endmodule

// File: rtl/shr_chan_decode.sv
module shr_chan_decode #(
    parameter int NUM_CH   = 32,
    parameter int MUX_WAYS = 8
) (
    input  logic [$clog2(NUM_CH)-1:0]          ch,
    input  logic                               window,
    output logic [NUM_CH/MUX_WAYS-1:0]         bank_en,
    output logic [$clog2(MUX_WAYS)-1:0]        mux_addr
);
    localparam int ADDR_W = $clog2(MUX_WAYS);
    localparam int BANKS  = NUM_CH / MUX_WAYS;
    localparam int CH_W   = $clog2(NUM_CH);

    assign mux_addr = ch[ADDR_W-1:0];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign bank_en[b] = window && (ch[CH_W-1:ADDR_W] == (CH_W-ADDR_W)'(b));
    end

endmodule

// File: rtl/shr_loopback.sv
module shr_loopback #(
    parameter int NUM_CH = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      lb_req,
    input  logic [$clog2(NUM_CH)-1:0] lb_ch,
    input  logic [$clog2(NUM_CH)-1:0] cur_ch,
    input  logic                      slot_end,
    output logic [$clog2(NUM_CH)-1:0] mon_sel,
    output logic                      lb_ready
);
    logic                      pend;
    logic [$clog2(NUM_CH)-1:0] tgt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= 1'b0;
            tgt      <= '0;
            mon_sel  <= '0;
            lb_ready <= 1'b0;
        end else if (lb_req) begin
            pend     <= 1'b1;
            tgt      <= lb_ch;
            lb_ready <= 1'b0;
        end else if (pend && slot_end && (cur_ch == tgt)) begin
            pend     <= 1'b0;
            mon_sel  <= tgt;
            lb_ready <= 1'b1;
        end
    end

endmodule

// File: rtl/shr_refresh_seq.sv
module shr_refresh_seq #(
    parameter int NUM_CH     = 32,
    parameter int CODE_W     = 12,
    parameter int MUX_WAYS   = 8,
    parameter int SLOT_CYC   = 1406,
    parameter int SETTLE_CYC = 500,
    parameter int SAMPLE_CYC = 600
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [$clog2(NUM_CH)-1:0]       wr_ch,
    input  logic [CODE_W-1:0]               wr_code,
    input  logic                            lb_req,
    input  logic [$clog2(NUM_CH)-1:0]       lb_ch,
    output logic [CODE_W-1:0]               dac_code,
    output logic [NUM_CH/MUX_WAYS-1:0]      bank_en,
    output logic [$clog2(MUX_WAYS)-1:0]     mux_addr,
    output logic                            sample_strobe,
    output logic                            pass_start,
    output logic [$clog2(NUM_CH)-1:0]       mon_sel,
    output logic                            lb_ready
);
    localparam int CH_W = $clog2(NUM_CH);
    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

    logic [CH_W-1:0]   cur_ch;
    logic              load_now;
    logic              sample_win;
    logic              slot_end;
    logic [CODE_W-1:0] rd_code;

    shr_code_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_ch   (wr_ch),
        .wr_code (wr_code),
        .rd_ch   (cur_ch),
        .rd_code (rd_code)
    );

    shr_slot_fsm #(
        .NUM_CH     (NUM_CH),
        .SLOT_CYC   (SLOT_CYC),
        .SETTLE_CYC (SETTLE_CYC),
        .SAMPLE_CYC (SAMPLE_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cur_ch     (cur_ch),
        .load_now   (load_now),
        .sample_win (sample_win),
        .slot_end   (slot_end),
        .pass_start (pass_start)
    );

    shr_chan_decode #(.NUM_CH(NUM_CH), .MUX_WAYS(MUX_WAYS)) u_dec (
        .ch       (cur_ch),
        .window   (sample_win),
        .bank_en  (bank_en),
        .mux_addr (mux_addr)
    );

    shr_loopback #(.NUM_CH(NUM_CH)) u_lb (
        .clk      (clk),
        .rst      (rst),
        .lb_req   (lb_req),
        .lb_ch    (lb_ch),
        .cur_ch   (cur_ch),
        .slot_end (slot_end),
        .mon_sel  (mon_sel),
        .lb_ready (lb_ready)
    );

    // DAC code latch: captured at the end of LOAD, held for the slot
    always_ff @(posedge clk) begin
        if (rst) begin
            dac_code <= MID_CODE;
        end else if (load_now) begin
            dac_code <= rd_code;
        end
    end

    assign sample_strobe = sample_win;

endmodule

// File: rtl/shr_refresh_seq_chk.sv
module shr_refresh_seq_chk #(
    parameter int NUM_CH     = 32,
    parameter int CODE_W     = 12,
    parameter int MUX_WAYS   = 8,
    parameter int SAMPLE_CYC = 600
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        lb_req,
    input  logic [CODE_W-1:0]           dac_code,
    input  logic [NUM_CH/MUX_WAYS-1:0]  bank_en,
    input  logic                        sample_strobe,
    input  logic                        pass_start,
    input  logic [$clog2(NUM_CH)-1:0]   mon_sel,
    input  logic                        lb_ready
);
    logic [31:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (sample_strobe) begin
            run_q <= run_q + 1;
        end else begin
            run_q <= '0;
        end
    end

    // R3
    strobe_len_chk: assert property (@(posedge clk) disable iff (rst)
        (!sample_strobe && run_q != 0) |-> (run_q == 32'(SAMPLE_CYC)));

    // R4
    bank_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        sample_strobe |-> ($countones(bank_en) == 1));

    // R4
    bank_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_strobe |-> (bank_en == '0));

    // R5
    dac_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_strobe && $past(sample_strobe)) |-> $stable(dac_code));

    // R9
    pass_single_chk: assert property (@(posedge clk) disable iff (rst)
        pass_start |=> !pass_start);

    // R8
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lb_ready && !lb_req) |=> (lb_ready && $stable(mon_sel)));

    // R8
    ready_clear_chk: assert property (@(posedge clk) disable iff (rst)
        lb_req |=> !lb_ready);

endmodule

bind shr_refresh_seq shr_refresh_seq_chk #(
    .NUM_CH     (NUM_CH),
    .CODE_W     (CODE_W),
    .MUX_WAYS   (MUX_WAYS),
    .SAMPLE_CYC (SAMPLE_CYC)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .lb_req        (lb_req),
    .dac_code      (dac_code),
    .bank_en       (bank_en),
    .sample_strobe (sample_strobe),
    .pass_start    (pass_start),
    .mon_sel       (mon_sel),
    .lb_ready      (lb_ready)
);

// File: tb/shr_refresh_seq_tb.sv
module shr_refresh_seq_tb;
    localparam int N      = 32;
    localparam int SLOT   = 16;
    localparam int SETTLE = 4;
    localparam int SAMPLE = 6;
    localparam int PASS   = SLOT * N;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_ch = '0;
    logic [11:0] wr_code = '0;
    logic        lb_req = 1'b0;
    logic [4:0]  lb_ch = '0;
    logic [11:0] dac_code;
    logic [3:0]  bank_en;
    logic [2:0]  mux_addr;
    logic        sample_strobe;
    logic        pass_start;
    logic [4:0]  mon_sel;
    logic        lb_ready;

    always #10 clk = ~clk;

    shr_refresh_seq #(
        .NUM_CH(N), .CODE_W(12), .MUX_WAYS(8),
        .SLOT_CYC(SLOT), .SETTLE_CYC(SETTLE), .SAMPLE_CYC(SAMPLE)
    ) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_code(wr_code),
        .lb_req(lb_req), .lb_ch(lb_ch), .dac_code(dac_code), .bank_en(bank_en),
        .mux_addr(mux_addr), .sample_strobe(sample_strobe), .pass_start(pass_start),
        .mon_sel(mon_sel), .lb_ready(lb_ready)
    );

    typedef struct {
        int          ch;
        logic [11:0] code;
        int          start;
    } exp_t;

    exp_t        sb_q[$];
    logic [11:0] shadow [N];
    int          checks = 0;
    int          failures = 0;
    int          cyc = 0;
    bit          done = 1'b0;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // predictor and monitor, sampled at the falling edge
    bit          prev_strobe = 1'b0;
    int          run_len = 0;
    exp_t        cur;
    bit          have_cur = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            sb_q.delete();
            prev_strobe = 1'b0;
            run_len = 0;
            have_cur = 1'b0;
        end else begin
            int c;
            c = cyc;
            // R2 expected slot order and LOAD position
            if (c % SLOT == 0) begin
                exp_t e;
                e.ch    = (c / SLOT) % N;
                e.code  = shadow[e.ch];
                e.start = c + 1 + SETTLE;
                sb_q.push_back(e);
            end
            // R9
            if (pass_start !== (c % PASS == 0)) begin
                failures++;
                $display("FAIL R9 cycle %0d pass_start=%0b expected %0b", c, pass_start, (c % PASS == 0));
            end else if (c % PASS == 0) begin
                checks++;
            end
            // R4 idle switches
            if (!sample_strobe && bank_en !== 4'b0) begin
                failures++;
                $display("FAIL R4 cycle %0d bank_en=%b expected 0000", c, bank_en);
            end
            if (sample_strobe && !prev_strobe) begin
                checks++;
                if (sb_q.size() == 0) begin
                    failures++;
                    $display("FAIL R2 cycle %0d unexpected strobe, expected none", c);
                    have_cur = 1'b0;
                end else begin
                    cur = sb_q.pop_front();
                    have_cur = 1'b1;
                    if (c != cur.start || dac_code !== cur.code ||
                        mux_addr !== 3'(cur.ch % 8) || bank_en !== (4'b1 << (cur.ch / 8))) begin
                        failures++;
                        $display("FAIL R2/R3/R4/R5/R6/R7 cycle %0d ch %0d: start=%0d dac=%h mux=%0d bank=%b expected start=%0d dac=%h mux=%0d bank=%b",
                                 c, cur.ch, c, dac_code, mux_addr, bank_en, cur.start, cur.code,
                                 cur.ch % 8, 4'b1 << (cur.ch / 8));
                    end
                end
                run_len = 0;
            end
            if (sample_strobe) begin
                run_len++;
                // R5 code held for the whole window
                if (have_cur && dac_code !== cur.code) begin
                    failures++;
                    $display("FAIL R5 cycle %0d dac=%h expected %h", c, dac_code, cur.code);
                end
            end
            if (!sample_strobe && prev_strobe) begin
                checks++;
                if (run_len != SAMPLE) begin
                    failures++;
                    $display("FAIL R3 strobe length %0d expected %0d", run_len, SAMPLE);
                end
            end
            prev_strobe = sample_strobe;
        end
    end

    task automatic wait_cycle(input int t);
        while (cyc != t) begin
            @(posedge clk);
            #2;
        end
    endtask

    // driver: one write, shadow updated after the capturing edge
    task automatic do_write(input int ch, input logic [11:0] val);
        wr_en   = 1'b1;
        wr_ch   = 5'(ch);
        wr_code = val;
        @(posedge clk);
        #2;
        wr_en = 1'b0;
        shadow[ch] = val;
    endtask

    task automatic loopback(input int ch, input string tag);
        int c;
        int e_end;
        bit early;
        c = cyc;
        lb_req = 1'b1;
        lb_ch  = 5'(ch);
        @(posedge clk);
        #2;
        lb_req = 1'b0;
        e_end = c + 1;
        while (!((e_end % SLOT == SLOT - 1) && ((e_end / SLOT) % N == ch))) e_end++;
        early = 1'b0;
        checks++;
        @(negedge clk);
        if (lb_ready !== 1'b0) begin
            failures++;
            $display("FAIL R8 %s ready=%0b right after request, expected 0", tag, lb_ready);
        end
        while (cyc < e_end + 1) begin
            if (lb_ready !== 1'b0) early = 1'b1;
            @(negedge clk);
        end
        checks++;
        if (early || lb_ready !== 1'b1 || mon_sel !== 5'(ch)) begin
            failures++;
            $display("FAIL R8 %s at cycle %0d early=%0b ready=%0b mon_sel=%0d expected ready=1 mon_sel=%0d",
                     tag, cyc, early, lb_ready, mon_sel, ch);
        end
        @(posedge clk);
        #2;
    endtask

    initial begin
        for (int i = 0; i < N; i++) shadow[i] = 12'h800;
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        checks++;
        if (dac_code !== 12'h800 || sample_strobe !== 1'b0 || bank_en !== 4'b0 || lb_ready !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset dac=%h strobe=%0b bank=%b ready=%0b expected 800 0 0000 0",
                     dac_code, sample_strobe, bank_en, lb_ready);
        end
        rst = 1'b0;

        // R6 write to an idle channel
        wait_cycle(20);  do_write(5, 12'h123);
        // R7 write inside the channel's own slot
        wait_cycle(56);  do_write(3, 12'hABC);
        // R7 write captured at the edge ending LOAD of ch7
        wait_cycle(112); do_write(7, 12'h456);
        // R6 write captured at the edge starting LOAD of ch9
        wait_cycle(143); do_write(9, 12'h9E1);
        // R8 loopback on a channel already passed this pass
        wait_cycle(200); loopback(10, "ch10");

        // R6 all channels rewritten, boundary codes on ch0 and ch1
        wait_cycle(1030);
        for (int i = 0; i < N; i++) begin
            logic [11:0] v;
            v = (i == 0) ? 12'hFFF : (i == 1) ? 12'h000 : 12'((i * 131) ^ 12'h5A5);
            do_write(i, v);
        end
        // R8 request captured exactly at slot end of the last channel
        wait_cycle(PASS * 3 - 1); loopback(31, "ch31_at_end");

        wait_cycle(PASS * 4 + 40);
        // R1 mid-run reset restores mid-scale and channel 0
        rst = 1'b1;
        for (int i = 0; i < N; i++) shadow[i] = 12'h800;
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (dac_code !== 12'h800 || lb_ready !== 1'b0) begin
            failures++;
            $display("FAIL R1 after reset dac=%h ready=%0b expected 800 0", dac_code, lb_ready);
        end
        rst = 1'b0;
        wait_cycle(PASS + 20);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired at cycle %0d, expected completion", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule